// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

The block watches a bank of input pins split into fixed groups of eight (three groups by default, 24 pins). Each pin has a mask bit. When any unmasked pin of a group changes level, in either direction, the group's shared flag is set. A flag stays set until software writes a one to its clear strobe or the interrupt logic pulses its acknowledge. The request output of a group is the flag qualified by that group's enable bit. A pin sees the same logic whether it is driven from outside or looped back from the chip's own output driver, so firmware can toggle a pin it drives to raise a software interrupt.

In the clocked path, every pin passes through a two-flop synchronizer. It is then compared with its previously sampled value. History is kept for every pin whatever its mask, so turning a mask bit on never replays an old change. A combinational wake output compares the raw pins with the held history. It can therefore signal a change on an enabled pin while the clock is stopped. It also stays high while an enabled request is pending.

Top module: `pin_toggle_irq`

## Requirements
- R1: Pins 8g to 8g+7 belong to group g: pins 0-7 drive flag bit 0, pins 8-15 drive flag bit 1, and pins 16-23 drive flag bit 2. A pin's mask bit is the bit of `mask_i` with the same index.
- R2: A change in either direction on a pin whose mask bit is 1 sets its group flag. The flag is visible after the third rising clock edge that follows the change and not after the second.
- R3: A change on a pin whose mask bit is 0 never sets any flag.
- R4: Setting a mask bit to 1 after its pin has already changed while masked does not set the flag.
- R5: A 1 on `clr_i[g]` or on `ack_i[g]` clears flag g at the next rising edge and leaves the other flags alone. If a qualifying change sets flag g in the same cycle, the set wins.
- R6: `irq_o[g]` is high exactly when flag g is set and `grp_en_i[g]` is 1. The flag is set whatever the enable.
- R7: `wake_o` rises combinationally, with no clock edge needed, when an unmasked pin of an enabled group differs from its sampled history. It is also high while any flag of an enabled group is set. It stays low for changes in disabled groups.
- R8: During reset all flags, requests and the wake output are 0. Pins that are already high when reset is released do not set any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock; may be stopped |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 24 | Monitored pin levels, bit n is pin n |
| mask_i | input | 24 | Per-pin contribute enable, bit n for pin n |
| grp_en_i | input | 3 | Per-group request enable |
| clr_i | input | 3 | Write-one clear strobe per group flag |
| ack_i | input | 3 | Acknowledge clear per group flag |
| flag_o | output | 3 | Group flags |
| irq_o | output | 3 | Group requests (flag AND enable) |
| wake_o | output | 1 | Clock-free wake indication |

## Verification
A pin change is due at the flag and request outputs three rising edges later: two synchronizer stages plus the history compare. The bench drives each change just after a falling edge. It checks that the flag is still low two falling edges later and high at the third. Clears and acknowledges act after one edge, so they are checked at the falling edge after the strobe. The wake output is combinational, so it is checked a nanosecond after the pin moves while the bench holds the clock stopped.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   localparam int unsigned PTC_GROUPS_DEF  = 3;
   localparam int unsigned PTC_GROUP_W_DEF = 8;
   localparam int unsigned PTC_SYNC_DEF    = 2;
endpackage

// File: rtl/ptc_sync.sv
module ptc_sync #(
   parameter int unsigned W      = 24,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ptc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ptc_arm.sv
module ptc_arm #(
   parameter int unsigned DEPTH = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic armed_o
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("ptc_arm: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0] arm_q;

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) arm_q <= '0;
         else         arm_q <= 1'b1;
      end
   end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) arm_q <= '0;
         else         arm_q <= {arm_q[DEPTH-2:0], 1'b1};
      end
   end

   assign armed_o = arm_q[DEPTH-1];
endmodule

// File: rtl/ptc_group.sv
module ptc_group #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         armed_i,
   input  logic [W-1:0] pin_sync_i,
   input  logic [W-1:0] pin_raw_i,
   input  logic [W-1:0] mask_i,
   input  logic         clr_i,
   input  logic         ack_i,
   output logic         tog_o,
   output logic         pend_o,
   output logic         flag_o
);
   if (W < 1) begin : g_bad_w
      $error("ptc_group: W must be at least 1");
   end

   logic [W-1:0] hist_q;
   logic         flag_q;
   logic         flag_d;

   // history follows every pin so a later mask change has no stale edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= pin_sync_i;
   end

   assign tog_o  = armed_i & (|((pin_sync_i ^ hist_q) & mask_i));
   assign pend_o = armed_i & (|((pin_raw_i  ^ hist_q) & mask_i));

   always_comb begin
      flag_d = flag_q;
      if (clr_i || ack_i) flag_d = 1'b0;
      if (tog_o)          flag_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flag_d;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq #(
   parameter int unsigned GROUPS      = ptc_pkg::PTC_GROUPS_DEF,
   parameter int unsigned GROUP_W     = ptc_pkg::PTC_GROUP_W_DEF,
   parameter int unsigned SYNC_STAGES = ptc_pkg::PTC_SYNC_DEF,
   localparam int unsigned PINS       = GROUPS * GROUP_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [PINS-1:0]   pin_i,
   input  logic [PINS-1:0]   mask_i,
   input  logic [GROUPS-1:0] grp_en_i,
   input  logic [GROUPS-1:0] clr_i,
   input  logic [GROUPS-1:0] ack_i,
   output logic [GROUPS-1:0] flag_o,
   output logic [GROUPS-1:0] irq_o,
   output logic              wake_o
);
   if (GROUPS < 1) begin : g_bad_groups
      $error("pin_toggle_irq: GROUPS must be at least 1");
   end

   logic [PINS-1:0]   pin_sync;
   logic              armed;
   logic [GROUPS-1:0] grp_tog;
   logic [GROUPS-1:0] grp_pend;

   ptc_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_i),
      .q_o   (pin_sync)
   );

   ptc_arm #(.DEPTH(SYNC_STAGES + 1)) u_arm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .armed_o(armed)
   );

   for (genvar g = 0; g < int'(GROUPS); g++) begin : g_grp
      ptc_group #(.W(GROUP_W)) u_grp (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .armed_i   (armed),
         .pin_sync_i(pin_sync[g*GROUP_W +: GROUP_W]),
         .pin_raw_i (pin_i[g*GROUP_W +: GROUP_W]),
         .mask_i    (mask_i[g*GROUP_W +: GROUP_W]),
         .clr_i     (clr_i[g]),
         .ack_i     (ack_i[g]),
         .tog_o     (grp_tog[g]),
         .pend_o    (grp_pend[g]),
         .flag_o    (flag_o[g])
      );
   end

   assign irq_o  = flag_o & grp_en_i;
   assign wake_o = |(grp_en_i & (grp_pend | flag_o));
endmodule

// File: rtl/ptc_chk.sv
module ptc_chk #(
   parameter int unsigned GROUPS = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [GROUPS-1:0] tog_i,
   input logic [GROUPS-1:0] clr_i,
   input logic [GROUPS-1:0] ack_i,
   input logic [GROUPS-1:0] en_i,
   input logic [GROUPS-1:0] flag_i,
   input logic [GROUPS-1:0] irq_i,
   input logic              wake_i
);
   // R2
   a_r2_toggle_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|tog_i) |=> ((flag_i & $past(tog_i)) == $past(tog_i)));

   // R5
   a_r5_clear_acts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|((clr_i | ack_i) & ~tog_i)) |=> ((flag_i & $past((clr_i | ack_i) & ~tog_i)) == '0));

   // R3
   a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flag_i & ~$past(flag_i) & ~$past(tog_i)) == '0));

   // R6
   a_r6_req_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((irq_i & ~en_i) == '0));

   // R7
   a_r7_wake_on_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(flag_i & en_i)) |-> wake_i);

   // R8
   always_comb begin
      if (!rst_ni) begin
         a_r8_reset_quiet: assert (flag_i == '0 && irq_i == '0 && !wake_i);
      end
   end
endmodule

bind pin_toggle_irq ptc_chk #(.GROUPS(GROUPS)) u_chk (
   .clk_i (clk_i),
   .rst_ni(rst_ni),
   .tog_i (grp_tog),
   .clr_i (clr_i),
   .ack_i (ack_i),
   .en_i  (grp_en_i),
   .flag_i(flag_o),
   .irq_i (irq_o),
   .wake_i(wake_o)
);

// File: tb/pin_toggle_irq_tb.sv
`timescale 1ns/1ps
module pin_toggle_irq_tb;
   logic        clk = 1'b0;
   logic        run = 1'b1;
   logic        rst_n = 1'b0;
   logic [23:0] pins = 24'h00F00F;
   logic [23:0] mask = 24'hFFFFFF;
   logic [2:0]  en  = 3'b111;
   logic [2:0]  clr = 3'b000;
   logic [2:0]  ack = 3'b000;
   logic [2:0]  flag, irq;
   logic        wake;
   int          nchk = 0;
   int          nerr = 0;
   bit          done = 0;

   always begin
      #2.5;
      if (run) clk = ~clk;
   end

   pin_toggle_irq u_dut (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .mask_i(mask),
      .grp_en_i(en), .clr_i(clr), .ack_i(ack),
      .flag_o(flag), .irq_o(irq), .wake_o(wake)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic flip(input int p);
      pins[p] = ~pins[p];
   endtask

   task automatic clear_all();
      clr = 3'b111;
      step(1);
      clr = 3'b000;
   endtask

   task automatic t_reset();
      step(2);
      chk("R8", "flag in reset", {29'd0, flag}, 32'd0);
      chk("R8", "irq in reset", {29'd0, irq}, 32'd0);
      chk("R8", "wake in reset", {31'd0, wake}, 32'd0);
      rst_n = 1'b1;
      step(6);
      chk("R8", "flag after release, high pins", {29'd0, flag}, 32'd0);
      chk("R8", "wake after release", {31'd0, wake}, 32'd0);
   endtask

   task automatic t_groups();
      flip(13);
      step(2);
      chk("R2", "flag not yet after two edges", {29'd0, flag}, 32'd0);
      step(1);
      chk("R1", "pin 13 sets group 1", {29'd0, flag}, 32'd2);
      clear_all();
      flip(0);
      step(3);
      chk("R1", "pin 0 sets group 0", {29'd0, flag}, 32'd1);
      clear_all();
      flip(23);
      step(3);
      chk("R1", "pin 23 sets group 2", {29'd0, flag}, 32'd4);
      clear_all();
   endtask

   task automatic t_edges();
      pins[5] = 1'b0;
      step(4);
      clear_all();
      pins[5] = 1'b1;
      step(3);
      chk("R2", "rising edge sets", {29'd0, flag}, 32'd1);
      clear_all();
      pins[5] = 1'b0;
      step(3);
      chk("R2", "falling edge sets", {29'd0, flag}, 32'd1);
      clear_all();
   endtask

   task automatic t_mask();
      mask[10] = 1'b0;
      step(1);
      flip(10);
      step(5);
      chk("R3", "masked pin ignored", {29'd0, flag}, 32'd0);
      flip(11);
      step(3);
      chk("R3", "unmasked neighbour sets", {29'd0, flag}, 32'd2);
      clear_all();
   endtask

   task automatic t_history();
      flip(10);
      step(4);
      mask[10] = 1'b1;
      step(5);
      chk("R4", "mask enable replays nothing", {29'd0, flag}, 32'd0);
      flip(10);
      step(3);
      chk("R4", "later change after enable sets", {29'd0, flag}, 32'd2);
      clear_all();
   endtask

   task automatic t_clear();
      flip(1);
      step(2);
      clr = 3'b001;
      step(1);
      clr = 3'b000;
      chk("R5", "set wins over clear", {29'd0, flag}, 32'd1);
      ack = 3'b001;
      step(1);
      ack = 3'b000;
      chk("R5", "ack clears", {29'd0, flag}, 32'd0);
      flip(9);
      flip(17);
      step(3);
      clr = 3'b010;
      step(1);
      clr = 3'b000;
      chk("R5", "clear only group 1", {29'd0, flag}, 32'd4);
      ack = 3'b100;
      step(1);
      ack = 3'b000;
      chk("R5", "ack group 2", {29'd0, flag}, 32'd0);
   endtask

   task automatic t_enable();
      en = 3'b101;
      flip(12);
      #1;
      chk("R7", "no wake for disabled group", {31'd0, wake}, 32'd0);
      step(3);
      chk("R6", "flag set while disabled", {29'd0, flag}, 32'd2);
      chk("R6", "no request while disabled", {29'd0, irq}, 32'd0);
      en = 3'b111;
      #1;
      chk("R6", "request after enable", {29'd0, irq}, 32'd2);
      chk("R7", "wake while request pending", {31'd0, wake}, 32'd1);
      step(1);
      clear_all();
      chk("R7", "wake low when idle", {31'd0, wake}, 32'd0);
   endtask

   task automatic t_wake();
      run = 1'b0;
      #10;
      flip(20);
      #1;
      chk("R7", "wake with clock stopped", {31'd0, wake}, 32'd1);
      chk("R7", "flag waits for clock", {29'd0, flag}, 32'd0);
      #10;
      run = 1'b1;
      step(3);
      chk("R7", "flag after clock restart", {29'd0, flag}, 32'd4);
      chk("R6", "request after restart", {29'd0, irq}, 32'd4);
      clear_all();
      chk("R7", "wake drops after clear", {31'd0, wake}, 32'd0);
   endtask

   initial begin
      t_reset();
      t_groups();
      t_edges();
      t_mask();
      t_history();
      t_clear();
      t_enable();
      t_wake();
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule